// File: doc/BRIEF.md
# Jack Detect Debounce and Power Gating

This block watches a headset jack through one of several general-purpose input pins, picked by a select field. It turns the raw, bouncing pin into a clean detection level. The pins are asynchronous to the main clock. Each pin passes through its own synchronizer before the selected one is sampled. Sampling happens only on a slow-timer tick, a single-cycle enable pulse in the main clock domain that fires once per half period of the slow timer. The clean level changes only after the new pin value has been seen on six ticks in a row. A step on the pin therefore reaches the output between 2.5 and 3.5 slow-timer periods after it happens. Shorter pulses are rejected.

The clean level drives automatic power control:

- **Bias enable.** The bias-generator enable is the host bias bit OR'd with the detection level. The detection term counts only when a separate jack-to-bias bit is set.
- **Driver enables.** There are four driver enables. Each one is the host's own power bit AND'd with a bit from one of two masks. One mask applies while the level reads 1 and the other while it reads 0.
- **Detection off.** While detection is disabled, the detection term passes every driver and adds nothing to the bias.

Top module: `jackdet_pwr_gate`

## Requirements
- R1: After reset the detection level is 0 and the debounce count is zero, so the driver enables equal host power AND the level-0 mask.
- R2: Only the pin whose index equals `pin_sel_i` (values 0, 1, 2) affects the detection level; changes on the other pins are ignored.
- R3: A steady change on the selected pin appears on `jack_level_o` no sooner than 2.5 and no later than 3.5 slow-timer periods later, where one period is two `slow_tick_i` pulses.
- R4: A pin pulse that is seen on fewer than six consecutive ticks, including any pulse of one or two slow-timer periods, leaves `jack_level_o` unchanged.
- R5: While no `slow_tick_i` pulse arrives, `jack_level_o` holds its value whatever the pin does.
- R6: While `det_en_i` is 0, the debounce count is cleared and the level holds. Every driver enable then equals its host power bit, and `bias_en_o` equals `host_bias_i`.
- R7: A change of `pin_sel_i` clears the debounce count, so the new pin must be seen on six fresh consecutive ticks.
- R8: `bias_en_o` = `host_bias_i` OR (`det_en_i` AND `jack_bias_en_i` AND `jack_level_o`).
- R9: `drv_en_o[i]` = `host_pwr_i[i]` AND mask bit i, where the mask is `mask_hi_i` when the level is 1 and `mask_lo_i` when it is 0. Bit 0 is the headphone pair, bit 1 the loudspeaker pair, bit 2 auxiliary output 1 and bit 3 auxiliary output 2.
- R10: A select value of 3 or above picks no pin and reads as a constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 3 | Raw asynchronous general-purpose pins |
| pin_sel_i | input | 2 | Index of the pin used for detection |
| det_en_i | input | 1 | Detection enable |
| jack_bias_en_i | input | 1 | Lets the detection level turn on the bias generator |
| slow_tick_i | input | 1 | One-cycle pulse, once per half slow-timer period |
| host_bias_i | input | 1 | Host bias-generator enable |
| host_pwr_i | input | 4 | Host power bits of the four drivers |
| mask_hi_i | input | 4 | Drivers allowed on while the level is 1 |
| mask_lo_i | input | 4 | Drivers allowed on while the level is 0 |
| jack_level_o | output | 1 | Debounced detection level |
| bias_en_o | output | 1 | Bias-generator enable |
| drv_en_o | output | 4 | Final driver enables |

## Verification
The hardest case to reach from the ports is a debounce run cut short just before it completes, because the count itself is invisible. The stimulus holds a changed pin for many tick periods while interrupting it regularly. It toggles `det_en_i` off for one cycle, or swaps between two pins that carry the same value, every three ticks. The level must stay put throughout. Once the interruptions stop, the level must follow within the window.

// File: rtl/jd_pkg.sv
package jd_pkg;
   localparam int NUM_DRV  = 4;
   localparam int DRV_HP   = 0;
   localparam int DRV_SPK  = 1;
   localparam int DRV_AUX1 = 2;
   localparam int DRV_AUX2 = 3;

   typedef logic [NUM_DRV-1:0] drv_vec_t;

   typedef struct packed {
      drv_vec_t on_hi;
      drv_vec_t on_lo;
   } gate_mask_t;
endpackage

// File: rtl/jd_pin_sync.sv
module jd_pin_sync #(
   parameter int NUM_PINS    = 3,
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic [SEL_W-1:0]    sel_i,
   output logic                pin_o
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("jd_pin_sync: SYNC_STAGES must be at least 2");
   end
   if ((1 << SEL_W) < NUM_PINS) begin : g_bad_sel
      $error("jd_pin_sync: SEL_W too narrow for NUM_PINS");
   end

   logic [NUM_PINS-1:0] synced;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], pins_i[p]};
      end
      assign synced[p] = chain[SYNC_STAGES-1];
   end

   // Out-of-range select reads as 0 (R10)
   always_comb begin
      pin_o = 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (sel_i == SEL_W'(i)) pin_o = synced[i];
      end
   end
endmodule

// File: rtl/jd_debounce.sv
module jd_debounce #(
   parameter int CONFIRM = 6,
   parameter int SEL_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             tick_i,
   input  logic             sample_i,
   output logic             level_o
);
   if (CONFIRM < 2) begin : g_bad_confirm
      $error("jd_debounce: CONFIRM must be at least 2");
   end

   localparam int CNT_W = $clog2(CONFIRM);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CONFIRM - 1);

   logic [CNT_W-1:0] cnt;
   logic [SEL_W-1:0] sel_q;
   logic             restart;

   assign restart = !en_i || (sel_i != sel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o <= 1'b0;
         cnt     <= '0;
         sel_q   <= '0;
      end else begin
         sel_q <= sel_i;
         if (restart) begin
            cnt <= '0;
         end else if (tick_i) begin
            if (sample_i == level_o) begin
               cnt <= '0;
            end else if (cnt == LAST) begin
               level_o <= sample_i;
               cnt     <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   p_flip_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o != $past(level_o)) |-> ($past(tick_i) && $past(cnt) == LAST));
   p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(level_o));
   p_clear_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (cnt == '0) && $stable(level_o));
   p_clear_on_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i != $past(sel_i)) |=> (cnt == '0));
endmodule

// File: rtl/jd_pwr_map.sv
module jd_pwr_map
   import jd_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       jack2bias_i,
   input  logic       level_i,
   input  logic       host_bias_i,
   input  drv_vec_t   host_pwr_i,
   input  gate_mask_t mask_i,
   output logic       bias_o,
   output drv_vec_t   drv_o
);
   drv_vec_t gate;
   logic     bias_d;
   drv_vec_t drv_d;

   always_comb begin
      if (!en_i)        gate = '1;
      else if (level_i) gate = mask_i.on_hi;
      else              gate = mask_i.on_lo;
      bias_d = host_bias_i | (en_i & jack2bias_i & level_i);
   end

   for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
      assign drv_d[d] = host_pwr_i[d] & gate[d];
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bias_o <= 1'b0;
            drv_o  <= '0;
         end else begin
            bias_o <= bias_d;
            drv_o  <= drv_d;
         end
      end
   end else begin : g_comb
      assign bias_o = bias_d;
      assign drv_o  = drv_d;

      p_bias_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
         host_bias_i |-> bias_o);
      p_drv_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (drv_o & ~host_pwr_i) == '0);
      p_pass_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !en_i |-> (drv_o == host_pwr_i) && (bias_o == host_bias_i));
   end
endmodule

// File: rtl/jackdet_pwr_gate.sv
module jackdet_pwr_gate
   import jd_pkg::*;
#(
   parameter int NUM_PINS        = 3,
   parameter int SEL_W           = 2,
   parameter int SYNC_STAGES     = 2,
   parameter int CONFIRM_SAMPLES = 6,
   parameter bit OUT_REG         = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic [SEL_W-1:0]    pin_sel_i,
   input  logic                det_en_i,
   input  logic                jack_bias_en_i,
   input  logic                slow_tick_i,
   input  logic                host_bias_i,
   input  logic [NUM_DRV-1:0]  host_pwr_i,
   input  logic [NUM_DRV-1:0]  mask_hi_i,
   input  logic [NUM_DRV-1:0]  mask_lo_i,
   output logic                jack_level_o,
   output logic                bias_en_o,
   output logic [NUM_DRV-1:0]  drv_en_o
);
   if (NUM_PINS < 1) begin : g_bad_pins
      $error("jackdet_pwr_gate: NUM_PINS must be at least 1");
   end

   logic       pin_s;
   gate_mask_t masks;

   assign masks.on_hi = mask_hi_i;
   assign masks.on_lo = mask_lo_i;

   jd_pin_sync #(
      .NUM_PINS    (NUM_PINS),
      .SEL_W       (SEL_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins_i (pins_i),
      .sel_i  (pin_sel_i),
      .pin_o  (pin_s)
   );

   jd_debounce #(
      .CONFIRM (CONFIRM_SAMPLES),
      .SEL_W   (SEL_W)
   ) u_deb (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (det_en_i),
      .sel_i    (pin_sel_i),
      .tick_i   (slow_tick_i),
      .sample_i (pin_s),
      .level_o  (jack_level_o)
   );

   jd_pwr_map #(
      .OUT_REG (OUT_REG)
   ) u_map (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (det_en_i),
      .jack2bias_i (jack_bias_en_i),
      .level_i     (jack_level_o),
      .host_bias_i (host_bias_i),
      .host_pwr_i  (host_pwr_i),
      .mask_i      (masks),
      .bias_o      (bias_en_o),
      .drv_o       (drv_en_o)
   );
endmodule

// File: tb/sim_jackdet_pwr_gate.sv
module sim_jackdet_pwr_gate;
   localparam int HALF = 10;   // cycles per tick, i.e. half a slow period
   localparam int PER  = 2 * HALF;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] pins = '0;
   logic [1:0] sel = '0;
   logic       en = 1'b1, j2b = 1'b1, hbias = 1'b0, tick = 1'b0, run = 1'b1;
   logic [3:0] hpwr = 4'hF, mhi = 4'b0101, mlo = 4'b1010;
   logic       level;
   logic       bias;
   logic [3:0] drv;

   int total = 0, bad = 0, tcnt = 0;
   logic exp_level = 1'b0;

   typedef struct {
      string      req;
      logic       lvl;
      logic       bias;
      logic [3:0] drv;
   } item_t;
   item_t sb[$];

   always #10 clk = ~clk;

   always @(posedge clk) begin
      tcnt <= (tcnt == HALF - 1) ? 0 : tcnt + 1;
      tick <= run && (tcnt == HALF - 1);
   end

   jackdet_pwr_gate u0 (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .pin_sel_i(sel),
      .det_en_i(en), .jack_bias_en_i(j2b), .slow_tick_i(tick),
      .host_bias_i(hbias), .host_pwr_i(hpwr), .mask_hi_i(mhi),
      .mask_lo_i(mlo), .jack_level_o(level), .bias_en_o(bias),
      .drv_en_o(drv)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_range(input string req, input int act, input int lo, input int hi);
      total++;
      if (act < lo || act > hi) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   // driver side: expected values from the requirement formulas
   task automatic expect_now(input string req);
      item_t it;
      logic [3:0] gate;
      gate = !en ? 4'hF : (exp_level ? mhi : mlo);
      it.req  = req;
      it.lvl  = exp_level;
      it.bias = hbias | (en & j2b & exp_level);
      it.drv  = hpwr & gate;
      sb.push_back(it);
      wait (sb.size() == 0);
   endtask

   // monitor side
   initial begin
      forever begin
         wait (sb.size() > 0);
         @(negedge clk);
         begin
            item_t it;
            it = sb.pop_front();
            chk({it.req, " level"}, int'(level), int'(it.lvl));
            chk({it.req, " bias"},  int'(bias),  int'(it.bias));
            chk({it.req, " drv"},   int'(drv),   int'(it.drv));
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // count cycles until the level reaches target; the pin was changed just before
   task automatic latency(input string req, input logic target);
      int n = 0;
      while (level !== target && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk_range(req, n, (5 * PER) / 2, (7 * PER) / 2);
      exp_level = target;
   endtask

   task automatic finish_run;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      cyc(5);
      rst_n = 1'b1;
      cyc(1);
      expect_now("R1 reset state");

      // R3 rising step, then R8/R9 with level 1
      pins[0] = 1'b1;
      latency("R3 rise latency", 1'b1);
      cyc(1);
      expect_now("R9 hi mask");
      j2b = 1'b0; cyc(1); expect_now("R8 jack2bias off");
      hbias = 1'b1; cyc(1); expect_now("R8 host bias");
      j2b = 1'b1; hbias = 1'b0; cyc(1);
      hpwr = 4'b0011; cyc(1); expect_now("R9 host bits");
      hpwr = 4'hF;

      // R4 glitches of one and two slow periods
      pins[0] = 1'b0; cyc(PER); pins[0] = 1'b1; cyc(120);
      expect_now("R4 glitch 1 period");
      pins[0] = 1'b0; cyc(2 * PER); pins[0] = 1'b1; cyc(120);
      expect_now("R4 glitch 2 periods");

      pins[0] = 1'b0;
      latency("R3 fall latency", 1'b0);
      cyc(1);
      expect_now("R9 lo mask");

      // R2 selection
      sel = 2'd1; pins[0] = 1'b1; cyc(150);
      expect_now("R2 unselected pin ignored");
      pins[1] = 1'b1;
      latency("R2 selected pin1", 1'b1);
      sel = 2'd2;
      latency("R2 selected pin2", 1'b0);

      // R10 out of range
      pins = 3'b111; sel = 2'd0;
      latency("R10 prep", 1'b1);
      sel = 2'd3;
      latency("R10 select 3 reads 0", 1'b0);

      // R5 no tick
      run = 1'b0; sel = 2'd0; cyc(200);
      expect_now("R5 hold without tick");
      run = 1'b1; cyc(80);
      exp_level = 1'b1;
      expect_now("R5 resumes with tick");

      // R6 disabled
      en = 1'b0; cyc(1);
      expect_now("R6 pass when disabled");
      en = 1'b1; pins[0] = 1'b0;
      for (int k = 0; k < 10; k++) begin
         cyc(3 * HALF); en = 1'b0; cyc(1); en = 1'b1;
      end
      expect_now("R6 counter cleared by disable");
      cyc(100);
      exp_level = 1'b0;
      expect_now("R6 follows after enable");

      // R7 select change restarts the count
      pins = 3'b011;
      for (int k = 0; k < 10; k++) begin
         cyc(3 * HALF); sel = (sel == 2'd0) ? 2'd1 : 2'd0;
      end
      expect_now("R7 counter cleared by select change");
      cyc(100);
      exp_level = 1'b1;
      expect_now("R7 follows after select settles");

      finish_run();
   end
endmodule